// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block models a small store queue and answers byte-forwarding questions from a two-stage load pipeline. Stores take queue entries in program order at the tail and free them in the same order at the head. Each entry keeps its address fields (virtual address, physical address, byte mask) and its data, and each has its own "known" flag. The address fields and the data are written later, independently, by entry index.

A load presents its virtual address, physical address, byte mask and a precomputed vector that marks which queue entries are older than itself. The vector is worked out one stage earlier, so the lookup needs no pointer arithmetic. In the first load stage the block returns an early per-byte forward mask. One clock later it returns the registered forward mask, the 16 data bytes, and three hazard indications: an older store with an unknown address, a covering store whose data has not arrived, and a disagreement between the entries hit by the virtual search and those hit by the physical search. The first two come with the index of the store the load must wait for. The third asks downstream logic for a flush. The queue depth must be a power of two.

Top module: `fwd_lookup`

## Requirements
- R1: After reset the queue is empty (`sq_empty_o`=1, `sq_full_o`=0). All second-stage outputs are zero.
- R2: An allocation takes the tail entry and clears its known flags. A retire frees the head entry. `sq_full_o` rises after DEPTH allocations without a retire. An allocation while full and a retire while empty are ignored. A wrap bit on each pointer separates full from empty.
- R3: Only entries that are allocated and have their bit set in `ld_older_i` take part in a query. Bit i stands for entry i. Address or data writes aimed at an unallocated entry are ignored.
- R4: A store hits a load when its address is known, address bits [ADDR_W-1:4] are equal, and the two byte masks share at least one set bit. Byte j of a mask covers data bits [8j+7:8j]. The virtual address decides forwarding.
- R5: When several hitting stores cover the same load byte, the most recently allocated one owns that byte. A byte is forwarded, with the owner's data, when the owner's data is known. Bytes that are not forwarded read as zero.
- R6: `fwd_mask_fast_o` answers in the same cycle as the query. `fwd_valid_o`, `fwd_mask_o`, `fwd_data_o` and the flags appear exactly one clock later. They are all zero in a cycle that follows no query.
- R7: `data_wait_o` is set when some load byte's owner has unknown data. `data_wait_idx_o` then names the oldest such owner.
- R8: `addr_wait_o` is set when a participating entry has an unknown address. `addr_wait_idx_o` then names the oldest such entry.
- R9: `va_pa_mismatch_o` is set when the set of entries hit by the virtual search differs from the set hit by the physical search.
- R10: The registered forward mask equals the early mask given for the same query one cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_alloc_i | input | 1 | Allocate the tail entry |
| st_retire_i | input | 1 | Free the head entry |
| st_addr_we_i | input | 1 | Write address fields of an entry |
| st_addr_idx_i | input | log2(DEPTH) | Entry written by the address port |
| st_vaddr_i | input | ADDR_W | Store virtual address |
| st_paddr_i | input | ADDR_W | Store physical address |
| st_mask_i | input | 16 | Store byte mask |
| st_data_we_i | input | 1 | Write data of an entry |
| st_data_idx_i | input | log2(DEPTH) | Entry written by the data port |
| st_data_i | input | 128 | Store data |
| ld_valid_i | input | 1 | Load query in the first stage |
| ld_vaddr_i | input | ADDR_W | Load virtual address |
| ld_paddr_i | input | ADDR_W | Load physical address |
| ld_mask_i | input | 16 | Load byte mask |
| ld_older_i | input | DEPTH | One bit per entry that is older than the load |
| sq_full_o | output | 1 | Queue full |
| sq_empty_o | output | 1 | Queue empty |
| fwd_mask_fast_o | output | 16 | Early forward mask, first stage |
| fwd_valid_o | output | 1 | Second-stage response present |
| fwd_mask_o | output | 16 | Forward mask, second stage |
| fwd_data_o | output | 128 | Forwarded bytes, second stage |
| data_wait_o | output | 1 | Covering store data unknown |
| data_wait_idx_o | output | log2(DEPTH) | Oldest store with missing data |
| addr_wait_o | output | 1 | Older store address unknown |
| addr_wait_idx_o | output | log2(DEPTH) | Oldest store with missing address |
| va_pa_mismatch_o | output | 1 | Virtual and physical hit sets differ |

## Verification
The bench sweeps all 256 older-entry vectors of an 8-entry queue over several load addresses and masks. It does this twice: once with entry ages that run across the index wrap, and once after a partial retire and reallocation has made low-index entries the youngest. A design that ranks age by index instead of by distance from the head would pick the wrong owner byte, or the wrong replay index, in the second pass. The fill includes a covering store with no data, a store with no address, a store whose physical line disagrees with its virtual line, and an overlap of several stores on the same bytes. A wrong owner choice therefore corrupts data, an unknown-data owner would forward garbage or miss its flag, and a per-entry mismatch compare done only on the virtual side would stay silent. A write to an entry that was just retired checks that freed entries cannot be revived by stray writes.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int unsigned LANE_BYTES = 16;
    localparam int unsigned LANE_OFS_W = $clog2(LANE_BYTES);
    localparam int unsigned LANE_BITS  = 8 * LANE_BYTES;

    typedef logic [LANE_BYTES-1:0] lane_mask_t;
    typedef logic [LANE_BITS-1:0]  lane_data_t;
endpackage

// File: rtl/fwd_sq_store.sv
module fwd_sq_store
    import fwd_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 20,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                alloc_i,
    input  logic                                retire_i,
    input  logic                                addr_we_i,
    input  logic [IDX_W-1:0]                    addr_idx_i,
    input  logic [ADDR_W-1:0]                   va_i,
    input  logic [ADDR_W-1:0]                   pa_i,
    input  lane_mask_t                          mask_i,
    input  logic                                data_we_i,
    input  logic [IDX_W-1:0]                    data_idx_i,
    input  lane_data_t                          data_i,
    output logic [DEPTH-1:0]                    used_o,
    output logic [DEPTH-1:0]                    addr_ok_o,
    output logic [DEPTH-1:0]                    data_ok_o,
    output logic [DEPTH-1:0][ADDR_W-1:0]        va_o,
    output logic [DEPTH-1:0][ADDR_W-1:0]        pa_o,
    output logic [DEPTH-1:0][LANE_BYTES-1:0]    mask_o,
    output logic [DEPTH-1:0][LANE_BITS-1:0]     data_o,
    output logic [IDX_W-1:0]                    head_o,
    output logic                                full_o,
    output logic                                empty_o
);
    typedef struct packed {
        logic [IDX_W:0]                      head;
        logic [IDX_W:0]                      tail;
        logic [DEPTH-1:0]                    used;
        logic [DEPTH-1:0]                    aok;
        logic [DEPTH-1:0]                    dok;
        logic [DEPTH-1:0][ADDR_W-1:0]        va;
        logic [DEPTH-1:0][ADDR_W-1:0]        pa;
        logic [DEPTH-1:0][LANE_BYTES-1:0]    msk;
        logic [DEPTH-1:0][LANE_BITS-1:0]     dat;
    } sq_state_t;

    sq_state_t s_d, s_q;
    logic      full_w, empty_w;

    assign full_w  = (s_q.head[IDX_W] != s_q.tail[IDX_W]) &&
                     (s_q.head[IDX_W-1:0] == s_q.tail[IDX_W-1:0]);
    assign empty_w = (s_q.head == s_q.tail);

    always_comb begin
        s_d = s_q;
        if (addr_we_i && s_q.used[addr_idx_i]) begin
            s_d.va[addr_idx_i]  = va_i;
            s_d.pa[addr_idx_i]  = pa_i;
            s_d.msk[addr_idx_i] = mask_i;
            s_d.aok[addr_idx_i] = 1'b1;
        end
        if (data_we_i && s_q.used[data_idx_i]) begin
            s_d.dat[data_idx_i] = data_i;
            s_d.dok[data_idx_i] = 1'b1;
        end
        if (retire_i && !empty_w) begin
            s_d.used[s_q.head[IDX_W-1:0]] = 1'b0;
            s_d.aok[s_q.head[IDX_W-1:0]]  = 1'b0;
            s_d.dok[s_q.head[IDX_W-1:0]]  = 1'b0;
            s_d.head                      = s_q.head + 1'b1;
        end
        if (alloc_i && !full_w) begin
            s_d.used[s_q.tail[IDX_W-1:0]] = 1'b1;
            s_d.aok[s_q.tail[IDX_W-1:0]]  = 1'b0;
            s_d.dok[s_q.tail[IDX_W-1:0]]  = 1'b0;
            s_d.tail                      = s_q.tail + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign used_o    = s_q.used;
    assign addr_ok_o = s_q.aok;
    assign data_ok_o = s_q.dok;
    assign va_o      = s_q.va;
    assign pa_o      = s_q.pa;
    assign mask_o    = s_q.msk;
    assign data_o    = s_q.dat;
    assign head_o    = s_q.head[IDX_W-1:0];
    assign full_o    = full_w;
    assign empty_o   = empty_w;
endmodule

// File: rtl/fwd_match_unit.sv
module fwd_match_unit
    import fwd_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 20,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                                ld_valid_i,
    input  logic [ADDR_W-1:0]                   ld_va_i,
    input  logic [ADDR_W-1:0]                   ld_pa_i,
    input  lane_mask_t                          ld_mask_i,
    input  logic [DEPTH-1:0]                    ld_older_i,
    input  logic [DEPTH-1:0]                    used_i,
    input  logic [DEPTH-1:0]                    addr_ok_i,
    input  logic [DEPTH-1:0]                    data_ok_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0]        va_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0]        pa_i,
    input  logic [DEPTH-1:0][LANE_BYTES-1:0]    mask_i,
    input  logic [DEPTH-1:0][LANE_BITS-1:0]     data_i,
    input  logic [IDX_W-1:0]                    head_i,
    output lane_mask_t                          fwd_mask_o,
    output lane_data_t                          fwd_data_o,
    output logic                                dwait_o,
    output logic [IDX_W-1:0]                    dwait_idx_o,
    output logic                                await_o,
    output logic [IDX_W-1:0]                    await_idx_o,
    output logic                                mismatch_o
);
    logic [DEPTH-1:0] cand, vhit, phit, nokaddr;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign cand[g]    = used_i[g] & ld_older_i[g];
        assign nokaddr[g] = cand[g] & ~addr_ok_i[g];
        assign vhit[g]    = cand[g] & addr_ok_i[g] & (|(mask_i[g] & ld_mask_i)) &
                            (va_i[g][ADDR_W-1:LANE_OFS_W] == ld_va_i[ADDR_W-1:LANE_OFS_W]);
        assign phit[g]    = cand[g] & addr_ok_i[g] & (|(mask_i[g] & ld_mask_i)) &
                            (pa_i[g][ADDR_W-1:LANE_OFS_W] == ld_pa_i[ADDR_W-1:LANE_OFS_W]);
    end

    logic [LANE_BYTES-1:0]            own_hit;
    logic [LANE_BYTES-1:0][IDX_W-1:0] own_idx;
    logic [DEPTH-1:0]                 blocked;

    // walk entries from oldest to youngest so the last hit is the youngest owner
    always_comb begin
        own_hit = '0;
        own_idx = '0;
        for (int b = 0; b < LANE_BYTES; b++) begin
            for (int k = 0; k < DEPTH; k++) begin
                logic [IDX_W-1:0] e;
                e = head_i + IDX_W'(k);
                if (vhit[e] && mask_i[e][b] && ld_mask_i[b]) begin
                    own_hit[b] = 1'b1;
                    own_idx[b] = e;
                end
            end
        end
    end

    always_comb begin
        fwd_mask_o = '0;
        fwd_data_o = '0;
        blocked    = '0;
        for (int b = 0; b < LANE_BYTES; b++) begin
            if (own_hit[b]) begin
                if (data_ok_i[own_idx[b]]) begin
                    fwd_mask_o[b]       = 1'b1;
                    fwd_data_o[8*b +: 8] = data_i[own_idx[b]][8*b +: 8];
                end else begin
                    blocked[own_idx[b]] = 1'b1;
                end
            end
        end
        if (!ld_valid_i) begin
            fwd_mask_o = '0;
            fwd_data_o = '0;
        end
    end

    // walk youngest to oldest so the last assignment names the oldest entry
    always_comb begin
        dwait_idx_o = '0;
        await_idx_o = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            logic [IDX_W-1:0] e;
            e = head_i + IDX_W'(k);
            if (blocked[e]) dwait_idx_o = e;
            if (nokaddr[e]) await_idx_o = e;
        end
    end

    assign dwait_o    = ld_valid_i & (|blocked);
    assign await_o    = ld_valid_i & (|nokaddr);
    assign mismatch_o = ld_valid_i & (|(vhit ^ phit));
endmodule

// File: rtl/fwd_lookup.sv
module fwd_lookup
    import fwd_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 20,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     st_alloc_i,
    input  logic                     st_retire_i,
    input  logic                     st_addr_we_i,
    input  logic [IDX_W-1:0]         st_addr_idx_i,
    input  logic [ADDR_W-1:0]        st_vaddr_i,
    input  logic [ADDR_W-1:0]        st_paddr_i,
    input  logic [LANE_BYTES-1:0]    st_mask_i,
    input  logic                     st_data_we_i,
    input  logic [IDX_W-1:0]         st_data_idx_i,
    input  logic [LANE_BITS-1:0]     st_data_i,
    input  logic                     ld_valid_i,
    input  logic [ADDR_W-1:0]        ld_vaddr_i,
    input  logic [ADDR_W-1:0]        ld_paddr_i,
    input  logic [LANE_BYTES-1:0]    ld_mask_i,
    input  logic [DEPTH-1:0]         ld_older_i,
    output logic                     sq_full_o,
    output logic                     sq_empty_o,
    output logic [LANE_BYTES-1:0]    fwd_mask_fast_o,
    output logic                     fwd_valid_o,
    output logic [LANE_BYTES-1:0]    fwd_mask_o,
    output logic [LANE_BITS-1:0]     fwd_data_o,
    output logic                     data_wait_o,
    output logic [IDX_W-1:0]         data_wait_idx_o,
    output logic                     addr_wait_o,
    output logic [IDX_W-1:0]         addr_wait_idx_o,
    output logic                     va_pa_mismatch_o
);
    logic [DEPTH-1:0]                 used_w, aok_w, dok_w;
    logic [DEPTH-1:0][ADDR_W-1:0]     va_w, pa_w;
    logic [DEPTH-1:0][LANE_BYTES-1:0] msk_w;
    logic [DEPTH-1:0][LANE_BITS-1:0]  dat_w;
    logic [IDX_W-1:0]                 head_w;

    fwd_sq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_i    (st_alloc_i),
        .retire_i   (st_retire_i),
        .addr_we_i  (st_addr_we_i),
        .addr_idx_i (st_addr_idx_i),
        .va_i       (st_vaddr_i),
        .pa_i       (st_paddr_i),
        .mask_i     (st_mask_i),
        .data_we_i  (st_data_we_i),
        .data_idx_i (st_data_idx_i),
        .data_i     (st_data_i),
        .used_o     (used_w),
        .addr_ok_o  (aok_w),
        .data_ok_o  (dok_w),
        .va_o       (va_w),
        .pa_o       (pa_w),
        .mask_o     (msk_w),
        .data_o     (dat_w),
        .head_o     (head_w),
        .full_o     (sq_full_o),
        .empty_o    (sq_empty_o)
    );

    lane_mask_t       m_mask;
    lane_data_t       m_data;
    logic             m_dw, m_aw, m_mm;
    logic [IDX_W-1:0] m_dw_idx, m_aw_idx;

    fwd_match_unit #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
        .ld_valid_i  (ld_valid_i),
        .ld_va_i     (ld_vaddr_i),
        .ld_pa_i     (ld_paddr_i),
        .ld_mask_i   (ld_mask_i),
        .ld_older_i  (ld_older_i),
        .used_i      (used_w),
        .addr_ok_i   (aok_w),
        .data_ok_i   (dok_w),
        .va_i        (va_w),
        .pa_i        (pa_w),
        .mask_i      (msk_w),
        .data_i      (dat_w),
        .head_i      (head_w),
        .fwd_mask_o  (m_mask),
        .fwd_data_o  (m_data),
        .dwait_o     (m_dw),
        .dwait_idx_o (m_dw_idx),
        .await_o     (m_aw),
        .await_idx_o (m_aw_idx),
        .mismatch_o  (m_mm)
    );

    assign fwd_mask_fast_o = m_mask;

    typedef struct packed {
        logic             valid;
        lane_mask_t       mask;
        lane_data_t       data;
        logic             dw;
        logic [IDX_W-1:0] dw_idx;
        logic             aw;
        logic [IDX_W-1:0] aw_idx;
        logic             mm;
    } resp_t;

    resp_t r_d, r_q;

    always_comb begin
        r_d = '0;
        if (ld_valid_i) begin
            r_d.valid  = 1'b1;
            r_d.mask   = m_mask;
            r_d.data   = m_data;
            r_d.dw     = m_dw;
            r_d.dw_idx = m_dw ? m_dw_idx : '0;
            r_d.aw     = m_aw;
            r_d.aw_idx = m_aw ? m_aw_idx : '0;
            r_d.mm     = m_mm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fwd_valid_o      = r_q.valid;
    assign fwd_mask_o       = r_q.mask;
    assign fwd_data_o       = r_q.data;
    assign data_wait_o      = r_q.dw;
    assign data_wait_idx_o  = r_q.dw_idx;
    assign addr_wait_o      = r_q.aw;
    assign addr_wait_idx_o  = r_q.aw_idx;
    assign va_pa_mismatch_o = r_q.mm;
endmodule

// File: rtl/fwd_lookup_chk.sv
module fwd_lookup_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LB    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_alloc_i,
    input logic             st_retire_i,
    input logic             sq_full_o,
    input logic             sq_empty_o,
    input logic             ld_valid_i,
    input logic [DEPTH-1:0] ld_older_i,
    input logic [LB-1:0]    fwd_mask_fast_o,
    input logic             fwd_valid_o,
    input logic [LB-1:0]    fwd_mask_o,
    input logic             data_wait_o,
    input logic             addr_wait_o,
    input logic             va_pa_mismatch_o
);
    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_full_o && st_alloc_i && !st_retire_i) |=> sq_full_o);

    // R2
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_empty_o && st_retire_i && !st_alloc_i) |=> sq_empty_o);

    // R6
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_i |=> fwd_valid_o);

    // R6
    no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid_i |=> (!fwd_valid_o && fwd_mask_o == '0));

    // R10
    fast_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_i |=> (fwd_mask_o == $past(fwd_mask_fast_o)));

    // R3
    no_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_i && ld_older_i == '0) |-> (fwd_mask_fast_o == '0));

    // R7 R8 R9
    flag_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wait_o || addr_wait_o || va_pa_mismatch_o) |-> fwd_valid_o);
endmodule

bind fwd_lookup fwd_lookup_chk #(.DEPTH(DEPTH), .LB(fwd_pkg::LANE_BYTES)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .st_alloc_i       (st_alloc_i),
    .st_retire_i      (st_retire_i),
    .sq_full_o        (sq_full_o),
    .sq_empty_o       (sq_empty_o),
    .ld_valid_i       (ld_valid_i),
    .ld_older_i       (ld_older_i),
    .fwd_mask_fast_o  (fwd_mask_fast_o),
    .fwd_valid_o      (fwd_valid_o),
    .fwd_mask_o       (fwd_mask_o),
    .data_wait_o      (data_wait_o),
    .addr_wait_o      (addr_wait_o),
    .va_pa_mismatch_o (va_pa_mismatch_o)
);

// File: tb/fwd_lookup_bench.sv
`timescale 1ns/1ps
module fwd_lookup_bench;
    localparam int DEPTH = 8;
    localparam int AW    = 20;
    localparam int IW    = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic st_alloc_i, st_retire_i, st_addr_we_i, st_data_we_i, ld_valid_i;
    logic [IW-1:0] st_addr_idx_i, st_data_idx_i;
    logic [AW-1:0] st_vaddr_i, st_paddr_i, ld_vaddr_i, ld_paddr_i;
    logic [15:0] st_mask_i, ld_mask_i;
    logic [127:0] st_data_i;
    logic [DEPTH-1:0] ld_older_i;
    logic sq_full_o, sq_empty_o, fwd_valid_o, data_wait_o, addr_wait_o, va_pa_mismatch_o;
    logic [15:0] fwd_mask_fast_o, fwd_mask_o;
    logic [127:0] fwd_data_o;
    logic [IW-1:0] data_wait_idx_o, addr_wait_idx_o;

    always #4 clk = ~clk;

    fwd_lookup #(.DEPTH(DEPTH), .ADDR_W(AW)) u_fwd_lookup (.*);

    int errors = 0, checks = 0;
    bit done = 0;

    bit m_used[DEPTH], m_aok[DEPTH], m_dok[DEPTH];
    logic [AW-1:0] m_va[DEPTH], m_pa[DEPTH];
    logic [15:0] m_msk[DEPTH];
    logic [127:0] m_dat[DEPTH];
    int m_seq[DEPTH];
    int seq_ctr = 0, m_head = 0, m_cnt = 0;

    localparam logic [AW-1:0] LA = 20'h12340, LB = 20'h56780;
    localparam logic [AW-1:0] PA = 20'hABC00, PB = 20'h33330, PX = 20'h77770;

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] pattern(input int e, input int salt);
        logic [127:0] d;
        for (int j = 0; j < 16; j++) d[8*j +: 8] = 8'(e * 37 + j * 11 + salt + 8'h5A);
        return d;
    endfunction

    task automatic do_alloc();
        st_alloc_i = 1'b1;
        @(negedge clk);
        st_alloc_i = 1'b0;
        if (m_cnt < DEPTH) begin
            int e = (m_head + m_cnt) % DEPTH;
            m_used[e] = 1; m_aok[e] = 0; m_dok[e] = 0; m_seq[e] = seq_ctr++;
            m_cnt++;
        end
    endtask

    task automatic do_retire();
        st_retire_i = 1'b1;
        @(negedge clk);
        st_retire_i = 1'b0;
        if (m_cnt > 0) begin
            m_used[m_head] = 0; m_aok[m_head] = 0; m_dok[m_head] = 0;
            m_head = (m_head + 1) % DEPTH;
            m_cnt--;
        end
    endtask

    task automatic wr_addr(input int e, input logic [AW-1:0] va, input logic [AW-1:0] pa, input logic [15:0] mk);
        st_addr_we_i = 1'b1; st_addr_idx_i = IW'(e);
        st_vaddr_i = va; st_paddr_i = pa; st_mask_i = mk;
        @(negedge clk);
        st_addr_we_i = 1'b0;
        if (m_used[e]) begin
            m_va[e] = va; m_pa[e] = pa; m_msk[e] = mk; m_aok[e] = 1;
        end
    endtask

    task automatic wr_data(input int e, input logic [127:0] d);
        st_data_we_i = 1'b1; st_data_idx_i = IW'(e); st_data_i = d;
        @(negedge clk);
        st_data_we_i = 1'b0;
        if (m_used[e]) begin
            m_dat[e] = d; m_dok[e] = 1;
        end
    endtask

    task automatic query(input logic [AW-1:0] va, input logic [AW-1:0] pa, input logic [15:0] lm, input logic [DEPTH-1:0] older);
        logic [15:0] em = '0;
        logic [127:0] ed = '0;
        logic [DEPTH-1:0] vh = '0, ph = '0, blk = '0;
        bit aw = 0, dw = 0;
        int awi = -1, dwi = -1;
        for (int e = 0; e < DEPTH; e++) begin
            bit cand = m_used[e] && older[e];
            if (cand && !m_aok[e]) begin
                aw = 1;
                if (awi < 0 || m_seq[e] < m_seq[awi]) awi = e;
            end
            if (cand && m_aok[e] && ((m_msk[e] & lm) != 0)) begin
                vh[e] = (m_va[e][AW-1:4] == va[AW-1:4]);
                ph[e] = (m_pa[e][AW-1:4] == pa[AW-1:4]);
            end
        end
        for (int b = 0; b < 16; b++) begin
            int best = -1;
            for (int e = 0; e < DEPTH; e++)
                if (vh[e] && m_msk[e][b] && lm[b] && (best < 0 || m_seq[e] > m_seq[best])) best = e;
            if (best >= 0) begin
                if (m_dok[best]) begin
                    em[b] = 1'b1;
                    ed[8*b +: 8] = m_dat[best][8*b +: 8];
                end else blk[best] = 1'b1;
            end
        end
        for (int e = 0; e < DEPTH; e++)
            if (blk[e]) begin
                dw = 1;
                if (dwi < 0 || m_seq[e] < m_seq[dwi]) dwi = e;
            end
        ld_valid_i = 1'b1; ld_vaddr_i = va; ld_paddr_i = pa; ld_mask_i = lm; ld_older_i = older;
        #1;
        chk("R10", "fast mask", 128'(fwd_mask_fast_o), 128'(em));
        @(negedge clk);
        chk("R6", "valid", 128'(fwd_valid_o), 128'(1));
        chk("R5", "mask", 128'(fwd_mask_o), 128'(em));
        chk("R4", "data", fwd_data_o, ed);
        chk("R7", "data wait", 128'(data_wait_o), 128'(dw));
        if (dw) chk("R7", "data wait idx", 128'(data_wait_idx_o), 128'(dwi));
        chk("R8", "addr wait", 128'(addr_wait_o), 128'(aw));
        if (aw) chk("R8", "addr wait idx", 128'(addr_wait_idx_o), 128'(awi));
        chk("R9", "mismatch", 128'(va_pa_mismatch_o), 128'(vh != ph));
        ld_valid_i = 1'b0;
    endtask

    task automatic sweep();
        for (int o = 0; o < 256; o++) begin
            query(LA | 20'h4, PA | 20'h9, 16'hFFFF, DEPTH'(o));
            query(LA, PA, 16'h00F0, DEPTH'(o));
            query(LB | 20'hF, PB, 16'hFFFF, DEPTH'(o));
            query(LA, PA, 16'h0000, DEPTH'(o));
        end
        @(negedge clk);
        chk("R6", "idle valid", 128'(fwd_valid_o), 128'(0));
        chk("R6", "idle mask", 128'(fwd_mask_o), 128'(0));
    endtask

    initial begin
        rst_n = 1'b0;
        {st_alloc_i, st_retire_i, st_addr_we_i, st_data_we_i, ld_valid_i} = '0;
        st_addr_idx_i = '0; st_data_idx_i = '0; st_vaddr_i = '0; st_paddr_i = '0;
        st_mask_i = '0; st_data_i = '0; ld_vaddr_i = '0; ld_paddr_i = '0;
        ld_mask_i = '0; ld_older_i = '0;
        for (int e = 0; e < DEPTH; e++) begin
            m_used[e] = 0; m_aok[e] = 0; m_dok[e] = 0; m_seq[e] = 0;
            m_va[e] = '0; m_pa[e] = '0; m_msk[e] = '0; m_dat[e] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1", "empty", 128'(sq_empty_o), 128'(1));
        chk("R1", "full", 128'(sq_full_o), 128'(0));
        chk("R1", "valid", 128'(fwd_valid_o), 128'(0));
        chk("R1", "flags", 128'({data_wait_o, addr_wait_o, va_pa_mismatch_o}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2: fill, overfill, partial retire, drain, underflow
        for (int i = 0; i < DEPTH; i++) do_alloc();
        chk("R2", "full after fill", 128'(sq_full_o), 128'(1));
        chk("R2", "not empty", 128'(sq_empty_o), 128'(0));
        do_alloc();
        do_retire();
        chk("R2", "full after one retire", 128'(sq_full_o), 128'(0));
        do_alloc();
        chk("R2", "full again", 128'(sq_full_o), 128'(1));
        for (int i = 0; i < DEPTH; i++) do_retire();
        chk("R2", "empty after drain", 128'(sq_empty_o), 128'(1));
        do_retire();
        chk("R2", "empty retire ignored", 128'(sq_empty_o), 128'(1));
        for (int i = 0; i < DEPTH; i++) do_alloc();
        chk("R2", "full after wrap fill", 128'(sq_full_o), 128'(1));

        // entry contents, ages start at head and wrap through entry 0
        wr_addr(0, LA, PA, 16'h00FF); wr_data(0, pattern(0, 0));
        wr_addr(1, LA, PA, 16'h0FF0); wr_data(1, pattern(1, 0));
        wr_addr(2, LB, PB, 16'hFFFF); wr_data(2, pattern(2, 0));
        wr_addr(3, LA, PA, 16'hF00F);
        wr_data(4, pattern(4, 0));
        wr_addr(5, LA, PX, 16'h00F0); wr_data(5, pattern(5, 0));
        wr_addr(6, LA | 20'h8, PA, 16'h3C00); wr_data(6, pattern(6, 0));
        wr_addr(7, LB, PA, 16'h0001); wr_data(7, pattern(7, 0));
        sweep();

        // R3: free three entries, write to a freed one, then reallocate as youngest
        for (int i = 0; i < 3; i++) do_retire();
        wr_addr(m_head == 0 ? DEPTH - 1 : m_head - 1, LA, PA, 16'hFFFF);
        query(LA, PA, 16'hFFFF, 8'hFF);
        for (int i = 0; i < 3; i++) do_alloc();
        wr_addr(1, LA, PA, 16'hFFFF); wr_data(1, pattern(1, 3));
        wr_addr(2, LA, PA, 16'h0F0F); wr_data(2, pattern(2, 3));
        wr_addr(3, LA, PA, 16'h00FF);
        sweep();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule